// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical scan timing for a display pipe. Software programs line and frame geometry, sync pulse positions, sync polarity and an interlace option through a small write-only register bus. The block then runs a pixel counter and a line counter and decodes from them a data-enable strobe and the two sync pulses. It also raises a vertical-blank interrupt. Pixel fetch, clock generation and the analog output stage sit outside the block. The pixel and line counters are exported so that a fetch engine can follow the scan.

The timing fields are not all stored the same way. Horizontal total, horizontal active width, vertical total and vertical active height are stored as the count minus one. The horizontal sync start is stored as its position minus one. The horizontal sync end and both vertical sync positions are stored as plain positions. Geometry, interlace and polarity writes land in a pending copy. That copy moves into the working copy only at a frame boundary, or at once while the controller is stopped, so a running frame never changes shape. The enables and the interrupt clear act on the next cycle.

A small scan state machine tracks where the raster is. The states are SCAN_OFF (controller stopped), SCAN_ACTIVE (inside the active lines) and SCAN_VBLANK (inside the vertical blanking lines). The transitions are: start, SCAN_OFF to SCAN_ACTIVE when the enable is seen. Blank entry, SCAN_ACTIVE to SCAN_VBLANK at the end of the last active line. Frame wrap, SCAN_VBLANK to SCAN_ACTIVE at the end of the last line of the frame. Stop, any state to SCAN_OFF when the enable is clear. Start goes straight to SCAN_VBLANK if blank entry falls on the same cycle. A frame wrap with no blanking lines keeps the state in SCAN_ACTIVE. The blank-entry transition is also the event that sets the interrupt status.

Top module: `raster_timer_top`

## Requirements
- R1: Register address 1 holds the horizontal total minus one in data bits [11:0] and the active width minus one in bits [23:12]. Address 3 holds the vertical total minus one in [11:0] and the active height minus one in [23:12]. `hcnt` counts from 0 up to the stored horizontal total field and then wraps to 0. `vcnt` advances on each such wrap and wraps to 0 after the stored vertical total field.
- R2: `de` is high exactly while `hcnt` is at or below the stored active-width field and `vcnt` is at or below the stored active-height field. It also requires the controller enable (control register, address 0, bit 0) and the output enable (bit 1) to be set.
- R3: Address 2 holds the horizontal sync start position minus one in [11:0] and the sync end position in [23:12]. The sync is active for `hcnt` from the start field plus one up to, but not including, the end field.
- R4: Address 4 holds the vertical sync start line in [11:0] and the end line in [23:12]. In a non-interlaced or even field the vertical sync is active for `vcnt` from the start field up to, but not including, the end field.
- R5: Control bit 3 set drives `hsync` active low, and control bit 4 set drives `vsync` active low. When a bit is clear, that sync is active high.
- R6: With control bit 1 clear, `de` stays low and both syncs rest at their inactive level, while the counters keep running.
- R7: With control bit 0 clear, `hcnt`, `vcnt` and `field` are held at 0 and all outputs are inactive. After bit 0 is written to 1, the counters read 0 in the next cycle and then advance by one each cycle.
- R8: The vertical-blank status bit sets in the cycle in which the counters first show `hcnt`=0 on the line after the last active line. The status bit is held until cleared, and `irq` equals the status bit AND control bit 5.
- R9: Writing the control register with bit 6 set clears the status bit. Writing bit 6 as 0 leaves the status bit unchanged.
- R10: Geometry, interlace and polarity values written while running take effect only from the first pixel of the next frame. While the controller is stopped they take effect on the next cycle.
- R11: With control bit 2 set, `field` toggles at each frame end. In the odd field (`field`=1) the vertical sync begins and ends half a line late, where the half-line point is (horizontal total)/2 rounded down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 24 | Register write data |
| hcnt | output | 12 | Pixel position within the line |
| vcnt | output | 12 | Line position within the frame |
| de | output | 1 | Active video strobe |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| field | output | 1 | Interlace field parity |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
The bench programs a small raster and follows the counters through whole frames, so the mixed encodings are exercised directly. A design that decoded the sync start without the minus-one adjustment would shift `hsync` one pixel early. A design that wrapped one count late would stretch every line. Geometry and polarity are rewritten in the middle of a frame; a design that applied them at once would wrap the current line at the new length or flip the sync mid-frame. The interrupt is checked at the exact first pixel of blanking, with the enable both off and on, and through clears written with the clear bit both 0 and 1. A level-style clear or an enable that gated the status bit itself would show up there. The interlace case checks the half-line vertical sync in the odd field and the parity toggle at each frame end.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    parameter int unsigned CW = 12;
    localparam int unsigned DW = 2 * CW;
    localparam int unsigned AW = 3;

    localparam logic [AW-1:0] ADR_CTRL  = 3'd0;
    localparam logic [AW-1:0] ADR_HGEOM = 3'd1;
    localparam logic [AW-1:0] ADR_HPULS = 3'd2;
    localparam logic [AW-1:0] ADR_VGEOM = 3'd3;
    localparam logic [AW-1:0] ADR_VPULS = 3'd4;

    localparam int unsigned B_RUN   = 0;
    localparam int unsigned B_OUTEN = 1;
    localparam int unsigned B_ILACE = 2;
    localparam int unsigned B_HNEG  = 3;
    localparam int unsigned B_VNEG  = 4;
    localparam int unsigned B_IRQEN = 5;
    localparam int unsigned B_VBCLR = 6;

    typedef enum logic [1:0] {
        SCAN_OFF    = 2'd0,
        SCAN_ACTIVE = 2'd1,
        SCAN_VBLANK = 2'd2
    } scan_state_t;

    typedef struct packed {
        logic [CW-1:0] h_tot_m1;
        logic [CW-1:0] h_act_m1;
        logic [CW-1:0] hp_beg_m1;
        logic [CW-1:0] hp_end;
        logic [CW-1:0] v_tot_m1;
        logic [CW-1:0] v_act_m1;
        logic [CW-1:0] vp_beg;
        logic [CW-1:0] vp_end;
        logic          ilace;
        logic          hneg;
        logic          vneg;
    } geom_t;

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          frame_end,
    output logic          run_en,
    output logic          out_en,
    output logic          irq_en,
    output logic          vb_clr,
    output logic          pend_ilace,
    output geom_t         live
);

    geom_t pend;

    assign vb_clr     = wr_en && (wr_addr == ADR_CTRL) && wr_data[B_VBCLR];
    assign pend_ilace = pend.ilace;

    // pending copy and immediate control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            run_en <= 1'b0;
            out_en <= 1'b0;
            irq_en <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    run_en     <= wr_data[B_RUN];
                    out_en     <= wr_data[B_OUTEN];
                    irq_en     <= wr_data[B_IRQEN];
                    pend.ilace <= wr_data[B_ILACE];
                    pend.hneg  <= wr_data[B_HNEG];
                    pend.vneg  <= wr_data[B_VNEG];
                end
                ADR_HGEOM: begin
                    pend.h_tot_m1 <= wr_data[CW-1:0];
                    pend.h_act_m1 <= wr_data[DW-1:CW];
                end
                ADR_HPULS: begin
                    pend.hp_beg_m1 <= wr_data[CW-1:0];
                    pend.hp_end    <= wr_data[DW-1:CW];
                end
                ADR_VGEOM: begin
                    pend.v_tot_m1 <= wr_data[CW-1:0];
                    pend.v_act_m1 <= wr_data[DW-1:CW];
                end
                ADR_VPULS: begin
                    pend.vp_beg <= wr_data[CW-1:0];
                    pend.vp_end <= wr_data[DW-1:CW];
                end
                default: ;
            endcase
        end
    end

    // working copy: follows pending while stopped, else only at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (!run_en || frame_end) begin
            live <= pend;
        end
    end

    assert_live_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !frame_end) |=> $stable(live));

endmodule

// File: rtl/rtg_scan.sv
module rtg_scan
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [CW-1:0] h_tot_m1,
    input  logic [CW-1:0] v_tot_m1,
    input  logic [CW-1:0] v_act_m1,
    input  logic          pend_ilace,
    output logic [CW-1:0] hcnt,
    output logic [CW-1:0] vcnt,
    output logic          field,
    output logic          frame_end,
    output logic          vb_set
);

    scan_state_t state, state_nx;
    logic line_end, last_act;

    assign line_end  = (hcnt == h_tot_m1);
    assign frame_end = run_en && line_end && (vcnt == v_tot_m1);
    assign last_act  = line_end && (vcnt == v_act_m1) && (v_act_m1 != v_tot_m1);
    assign vb_set    = run_en && (state != SCAN_VBLANK) && last_act;

    always_comb begin
        state_nx = state;
        unique case (state)
            SCAN_OFF: begin
                if (run_en) state_nx = last_act ? SCAN_VBLANK : SCAN_ACTIVE;
            end
            SCAN_ACTIVE: begin
                if (!run_en)       state_nx = SCAN_OFF;
                else if (last_act) state_nx = SCAN_VBLANK;
            end
            SCAN_VBLANK: begin
                if (!run_en)        state_nx = SCAN_OFF;
                else if (frame_end) state_nx = SCAN_ACTIVE;
            end
            default: state_nx = SCAN_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SCAN_OFF;
        else        state <= state_nx;
    end

    // counters and field parity
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            hcnt  <= '0;
            vcnt  <= '0;
            field <= 1'b0;
        end else begin
            if (line_end) begin
                hcnt <= '0;
                vcnt <= (vcnt == v_tot_m1) ? '0 : vcnt + 1'b1;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
            if (frame_end) field <= pend_ilace ? ~field : 1'b0;
        end
    end

    assert_hwrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && line_end) |=> (hcnt == '0));
    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (hcnt == '0 && vcnt == '0 && !field));
    assert_blank_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SCAN_VBLANK) |-> (vcnt > v_act_m1));

endmodule

// File: rtl/rtg_sync.sv
module rtg_sync
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          out_en,
    input  logic [CW-1:0] hcnt,
    input  logic [CW-1:0] vcnt,
    input  logic          field,
    input  logic [CW-1:0] h_tot_m1,
    input  logic [CW-1:0] h_act_m1,
    input  logic [CW-1:0] hp_beg_m1,
    input  logic [CW-1:0] hp_end,
    input  logic [CW-1:0] v_act_m1,
    input  logic [CW-1:0] vp_beg,
    input  logic [CW-1:0] vp_end,
    input  logic          ilace,
    input  logic          hneg,
    input  logic          vneg,
    output logic          de,
    output logic          hsync,
    output logic          vsync
);

    logic [CW:0] half;
    logic        h_on, v_even, v_odd, v_on, gate, after_half;

    assign half       = ({1'b0, h_tot_m1} + 1'b1) >> 1;
    assign after_half = ({1'b0, hcnt} >= half);
    assign gate       = run_en && out_en;

    always_comb begin
        h_on   = (hcnt > hp_beg_m1) && (hcnt < hp_end);
        v_even = (vcnt >= vp_beg) && (vcnt < vp_end);
        v_odd  = ((vcnt > vp_beg) || ((vcnt == vp_beg) && after_half)) &&
                 ((vcnt < vp_end) || ((vcnt == vp_end) && !after_half));
        v_on   = (ilace && field) ? v_odd : v_even;
    end

    assign de    = gate && (hcnt <= h_act_m1) && (vcnt <= v_act_m1);
    assign hsync = (gate && h_on) ^ hneg;
    assign vsync = (gate && v_on) ^ vneg;

    assert_gate_de_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !de);
    assert_de_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hcnt <= h_act_m1));

endmodule

// File: rtl/rtg_irq.sv
module rtg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic vb_set,
    input  logic vb_clr,
    input  logic irq_en,
    output logic irq
);

    logic vb_stat;

    always_ff @(posedge clk) begin
        if (!rst_n)      vb_stat <= 1'b0;
        else if (vb_set) vb_stat <= 1'b1;
        else if (vb_clr) vb_stat <= 1'b0;
    end

    assign irq = vb_stat && irq_en;

    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vb_clr && !vb_set) |=> !vb_stat);
    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vb_set |=> vb_stat);

endmodule

// File: rtl/raster_timer_top.sv
module raster_timer_top
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [CW-1:0] hcnt,
    output logic [CW-1:0] vcnt,
    output logic          de,
    output logic          hsync,
    output logic          vsync,
    output logic          field,
    output logic          irq
);

    geom_t live;
    logic  run_en, out_en, irq_en, vb_clr, vb_set, pend_ilace, frame_end;

    rtg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_end(frame_end), .run_en(run_en),
        .out_en(out_en), .irq_en(irq_en), .vb_clr(vb_clr),
        .pend_ilace(pend_ilace), .live(live)
    );

    rtg_scan u_scan (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .h_tot_m1(live.h_tot_m1), .v_tot_m1(live.v_tot_m1),
        .v_act_m1(live.v_act_m1), .pend_ilace(pend_ilace),
        .hcnt(hcnt), .vcnt(vcnt), .field(field),
        .frame_end(frame_end), .vb_set(vb_set)
    );

    rtg_sync u_sync (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .out_en(out_en),
        .hcnt(hcnt), .vcnt(vcnt), .field(field),
        .h_tot_m1(live.h_tot_m1), .h_act_m1(live.h_act_m1),
        .hp_beg_m1(live.hp_beg_m1), .hp_end(live.hp_end),
        .v_act_m1(live.v_act_m1), .vp_beg(live.vp_beg), .vp_end(live.vp_end),
        .ilace(live.ilace), .hneg(live.hneg), .vneg(live.vneg),
        .de(de), .hsync(hsync), .vsync(vsync)
    );

    rtg_irq u_irq (
        .clk(clk), .rst_n(rst_n), .vb_set(vb_set), .vb_clr(vb_clr),
        .irq_en(irq_en), .irq(irq)
    );

endmodule

// File: tb/test_raster_timer_top.sv
module test_raster_timer_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [23:0] wr_data;
    logic [11:0] hcnt, vcnt;
    logic        de, hsync, vsync, field, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench raster: 10 pixels x 6 lines, 6x4 active
    localparam int HT = 10;
    localparam int VT = 6;
    localparam logic [23:0] HGEOM = (24'd5 << 12) | 24'd9;
    localparam logic [23:0] HPULS = (24'd9 << 12) | 24'd6;  // active h = 7,8
    localparam logic [23:0] VGEOM = (24'd3 << 12) | 24'd5;
    localparam logic [23:0] VPULS = (24'd5 << 12) | 24'd4;  // active v = 4
    localparam logic [23:0] RUN = 24'h01, OUT = 24'h02, ILC = 24'h04,
                            HN = 24'h08, VN = 24'h10, IE = 24'h20, CLR = 24'h40;
    localparam logic [23:0] CB = RUN | OUT;

    always #4 clk = ~clk;

    raster_timer_top i_raster_timer_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hcnt(hcnt), .vcnt(vcnt), .de(de),
        .hsync(hsync), .vsync(vsync), .field(field), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_frame();
        step();
        for (int i = 0; i < 300; i++) begin
            if (hcnt == 0 && vcnt == 0) break;
            step();
        end
    endtask

    task automatic wait_pos(input int h, input int v);
        for (int i = 0; i < 300; i++) begin
            if (hcnt == h && vcnt == v) break;
            step();
        end
    endtask

    function automatic int e_hs(int h);
        return (h >= 7 && h < 9) ? 1 : 0;
    endfunction

    function automatic int e_vs(int h, int v, bit odd);
        if (!odd) return (v == 4) ? 1 : 0;
        return ((v == 4 && h >= 5) || (v == 5 && h < 5)) ? 1 : 0;
    endfunction

    function automatic int e_de(int h, int v);
        return (h <= 5 && v <= 3) ? 1 : 0;
    endfunction

    task automatic check_frame(input bit hn, input bit vn, input bit odd);
        for (int i = 0; i < HT * VT; i++) begin
            chk("R2", de, e_de(hcnt, vcnt));
            chk(hn ? "R5" : "R3", hsync, e_hs(hcnt) ^ hn);
            chk(odd ? "R11" : (vn ? "R5" : "R4"), vsync, e_vs(hcnt, vcnt, odd) ^ vn);
            step();
        end
    endtask

    task automatic track(input string req, input int n, input int h0,
                         input int ht1, input int ht2);
        int eh = h0, ev = 0, cur = ht1;
        for (int i = 0; i < n; i++) begin
            chk(req, hcnt, eh);
            chk(req, vcnt, ev);
            if (eh == cur - 1) begin
                eh = 0;
                if (ev == VT - 1) begin ev = 0; cur = ht2; end
                else ev++;
            end else begin
                eh++;
            end
            step();
        end
    endtask

    task automatic t_reset();
        chk("R7", hcnt, 0); chk("R7", vcnt, 0); chk("R7", de, 0);
        chk("R7", hsync, 0); chk("R7", vsync, 0); chk("R7", field, 0);
        chk("R8", irq, 0);
    endtask

    task automatic t_count();   // R1
        wr(3'd1, HGEOM); wr(3'd2, HPULS); wr(3'd3, VGEOM); wr(3'd4, VPULS);
        wr(3'd0, CB);
        track("R1", 2 * HT * VT + 10, 0, HT, HT);
    endtask

    task automatic t_window();  // R2 R3 R4
        sync_frame();
        check_frame(0, 0, 0);
    endtask

    task automatic t_polarity(); // R5, with R10 deferral
        sync_frame();
        wr(3'd0, CB | HN | VN);
        chk("R10", hsync, e_hs(hcnt));
        chk("R10", vsync, 0);
        sync_frame();
        check_frame(1, 1, 0);
    endtask

    task automatic t_outgate(); // R6
        int ph;
        wr(3'd0, RUN | HN | VN);
        for (int i = 0; i < HT * VT; i++) begin
            ph = hcnt;
            chk("R6", de, 0); chk("R6", hsync, 1); chk("R6", vsync, 1);
            step();
            chk("R6", hcnt, (ph + 1) % HT);
        end
        wr(3'd0, CB);
        sync_frame();
    endtask

    task automatic t_stop();    // R7
        wr(3'd0, 24'h0);
        step();
        for (int i = 0; i < 10; i++) begin
            chk("R7", hcnt, 0); chk("R7", vcnt, 0); chk("R7", de, 0);
            chk("R7", hsync, 0); chk("R7", vsync, 0);
            step();
        end
        wr(3'd0, CB);
        chk("R7", hcnt, 0);
        step();
        chk("R7", hcnt, 1);
        step();
        chk("R7", hcnt, 2);
    endtask

    task automatic t_midframe(); // R10
        sync_frame();
        wr(3'd1, (24'd5 << 12) | 24'd7);
        track("R10", 2 * HT * VT, 2, HT, 8);
        wr(3'd1, HGEOM);
        sync_frame();
        sync_frame();
        track("R10", HT * VT, 0, HT, HT);
    endtask

    task automatic t_vblank();  // R8 R9
        int prev;
        sync_frame();
        wr(3'd0, CB | CLR);
        wait_pos(0, 4);
        chk("R8", irq, 0);
        wr(3'd0, CB | IE);
        chk("R8", irq, 1);
        wr(3'd0, CB | IE);
        chk("R9", irq, 1);
        wr(3'd0, CB | IE | CLR);
        chk("R9", irq, 0);
        prev = irq;
        for (int i = 0; i < 300; i++) begin
            if (hcnt == 0 && vcnt == 4) break;
            prev = irq;
            step();
        end
        chk("R8", prev, 0);
        chk("R8", irq, 1);
        wr(3'd0, CB | CLR);
        chk("R8", irq, 0);
    endtask

    task automatic t_interlace(); // R11
        sync_frame();
        wr(3'd0, CB | ILC);
        chk("R11", field, 0);
        sync_frame();
        chk("R11", field, 1);
        check_frame(0, 0, 1);
        chk("R11", field, 0);
        check_frame(0, 0, 0);
        chk("R11", field, 1);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_count();
        t_window();
        t_polarity();
        t_outgate();
        t_stop();
        t_midframe();
        t_vblank();
        t_interlace();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule